// File: doc/BRIEF.md
# Instruction Operand Decoder

This block turns a 16-bit instruction word for a small single-accumulator (one read, one write) machine with an 8-bit datapath into its control fields and its second operand. It takes the opcode from the top nibble and works out which form the word uses. In the wide-constant form the low byte is the operand. In the source form the operand is either the register file read data or a 4-bit short constant widened to 8 bits.

The short constant of the add opcode has no zero code. Its sixteen codes cover -8..-1 and +1..+8, because adding zero would do nothing. For every other opcode the short constant is sign-extended as it is. The block also flags the two reserved words: all-zeros is a no-op carrying the NEVER condition, and all-ones is a trap request carrying the ALWAYS condition.

The block is purely combinational. The register index it produces feeds the register file read port, and the read data returns on `rf_rdata` in the same cycle.

Top module: `opnd_decoder`

## Requirements
- R1: `opcode` always equals instruction bits 15:12.
- R2: When bit 10 is 1 the word is in wide-constant form: `is_imm8`=1, `operand` = bits 7:0, and `cond_sel` = 1 (ALWAYS).
- R3: When bit 10 is 0 the word is in source form. Bit 9 = 1 selects the short-constant source (`is_short`=1) and bit 9 = 0 selects the register source. `is_imm8` and `is_short` are never both 1.
- R4: In the register source form, `operand` = `rf_rdata`. In every form, `reg_idx` = bits 2:0.
- R5: For opcode 6 (add) with the short-constant source, bits 3:0 read as a two's-complement code. Codes 0..7 give +1..+8 (8'h01..8'h08), codes 8..15 give -8..-1 (8'hF8..8'hFF), and the operand is never zero.
- R6: For any other opcode with the short-constant source, `operand` is bits 3:0 sign-extended to 8 bits.
- R7: In source form, `cond_sel` = bits 6:4, where code 0 means NEVER and code 1 means ALWAYS.
- R8: Word 16'h0000 raises `is_nop` with `cond_sel` = 0 (NEVER). No other word raises `is_nop`.
- R9: Word 16'hFFFF raises `inv_trap` in wide-constant form with `cond_sel` = 1 and `operand` = 8'hFF. No other word raises `inv_trap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 16 | Instruction word to decode |
| rf_rdata | input | 8 | Register file read data for `reg_idx` |
| opcode | output | 4 | Main opcode field |
| is_imm8 | output | 1 | Wide-constant form |
| is_short | output | 1 | Source form with short-constant source |
| operand | output | 8 | Second operand |
| reg_idx | output | 3 | Source register index |
| cond_sel | output | 3 | Condition code (0 NEVER, 1 ALWAYS) |
| is_nop | output | 1 | Reserved all-zeros word |
| inv_trap | output | 1 | Reserved all-ones word, trap request |

## Verification
The reserved-word flags and the form decode act on the same word. All-ones is both a trap and a wide-constant word, so it must also give operand 8'hFF and condition ALWAYS. All-zeros is both a no-op and a register-source word, so it must also pass `rf_rdata` through with condition NEVER. The bench applies these two words, and their single-bit neighbours 16'h0001 and 16'hFFFE, with distinctive read data, and checks every output field in the same sample. A sweep of all sixteen short codes, once under the add opcode and once under another opcode, separates the skip-zero expansion from plain sign extension.

// File: rtl/opnd_dec_pkg.sv
package opnd_dec_pkg;

    parameter int INSTR_W   = 16;
    parameter int DATA_W    = 8;
    parameter int OPC_W     = 4;
    parameter int REG_IDX_W = 3;
    parameter int COND_W    = 3;
    parameter int SIMM_W    = 4;

    localparam int OPC_LSB   = INSTR_W - OPC_W;
    localparam int FORM_BIT  = 10;
    localparam int SRC_BIT   = 9;
    localparam int COND_LSB  = 4;
    localparam int SIMM_MAX  = (1 << (SIMM_W - 1)) - 1;

    localparam logic [OPC_W-1:0]   OP_ADD      = OPC_W'(6);
    localparam logic [COND_W-1:0]  COND_NEVER  = '0;
    localparam logic [COND_W-1:0]  COND_ALWAYS = COND_W'(1);
    localparam logic [INSTR_W-1:0] WORD_NOP    = '0;
    localparam logic [INSTR_W-1:0] WORD_INV    = '1;

    typedef enum logic [1:0] {
        SRC_REG   = 2'd0,
        SRC_SHORT = 2'd1,
        SRC_WIDE  = 2'd2
    } src_kind_e;

    typedef struct packed {
        logic [OPC_W-1:0]     opc;
        src_kind_e            kind;
        logic [COND_W-1:0]    cond;
        logic [REG_IDX_W-1:0] ridx;
        logic [SIMM_W-1:0]    simm;
        logic [DATA_W-1:0]    imm8;
    } fields_t;

    // Widen a short code: sign extension, with the zero code skipped for add.
    function automatic logic [DATA_W-1:0] widen_short(
        input logic [SIMM_W-1:0] code,
        input logic              skip_zero
    );
        logic [DATA_W-1:0] ext;
        ext = {{(DATA_W-SIMM_W){code[SIMM_W-1]}}, code};
        if (skip_zero && !code[SIMM_W-1])
            ext = ext + DATA_W'(1);
        return ext;
    endfunction

endpackage

// File: rtl/opnd_field_split.sv
module opnd_field_split
    import opnd_dec_pkg::*;
(
    input  logic [INSTR_W-1:0] word,
    output fields_t            flds
);
    always_comb begin
        flds.opc  = word[INSTR_W-1:OPC_LSB];
        flds.ridx = word[REG_IDX_W-1:0];
        flds.simm = word[SIMM_W-1:0];
        flds.imm8 = word[DATA_W-1:0];
        if (word[FORM_BIT]) begin
            flds.kind = SRC_WIDE;
            flds.cond = COND_ALWAYS;
        end else begin
            flds.kind = word[SRC_BIT] ? SRC_SHORT : SRC_REG;
            flds.cond = word[COND_LSB+COND_W-1:COND_LSB];
        end
    end
endmodule

// File: rtl/opnd_simm_widen.sv
module opnd_simm_widen
    import opnd_dec_pkg::*;
(
    input  logic [SIMM_W-1:0] code,
    input  logic              is_add,
    output logic [DATA_W-1:0] value
);
    always_comb value = widen_short(code, is_add);

    always_comb begin
        if (is_add)
            a_r5_add_nonzero: assert (value != '0);
    end
endmodule

// File: rtl/opnd_select.sv
module opnd_select
    import opnd_dec_pkg::*;
(
    input  src_kind_e         kind,
    input  logic [DATA_W-1:0] imm8,
    input  logic [DATA_W-1:0] short_val,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] operand
);
    always_comb begin
        unique case (kind)
            SRC_WIDE:  operand = imm8;
            SRC_SHORT: operand = short_val;
            default:   operand = rdata;
        endcase
    end
endmodule

// File: rtl/opnd_decoder.sv
module opnd_decoder
    import opnd_dec_pkg::*;
(
    input  logic [INSTR_W-1:0]   instr_word,
    input  logic [DATA_W-1:0]    rf_rdata,
    output logic [OPC_W-1:0]     opcode,
    output logic                 is_imm8,
    output logic                 is_short,
    output logic [DATA_W-1:0]    operand,
    output logic [REG_IDX_W-1:0] reg_idx,
    output logic [COND_W-1:0]    cond_sel,
    output logic                 is_nop,
    output logic                 inv_trap
);
    fields_t           flds;
    logic [DATA_W-1:0] short_val;

    opnd_field_split u_split (
        .word (instr_word),
        .flds (flds)
    );

    opnd_simm_widen u_widen (
        .code   (flds.simm),
        .is_add (flds.opc == OP_ADD),
        .value  (short_val)
    );

    opnd_select u_sel (
        .kind      (flds.kind),
        .imm8      (flds.imm8),
        .short_val (short_val),
        .rdata     (rf_rdata),
        .operand   (operand)
    );

    assign opcode   = flds.opc;
    assign is_imm8  = (flds.kind == SRC_WIDE);
    assign is_short = (flds.kind == SRC_SHORT);
    assign reg_idx  = flds.ridx;
    assign cond_sel = flds.cond;
    assign is_nop   = (instr_word == WORD_NOP);
    assign inv_trap = (instr_word == WORD_INV);

    always_comb begin
        a_r3_one_form: assert (!(is_imm8 && is_short));
        a_r8_nop_never: assert (!is_nop || (cond_sel == COND_NEVER && !is_imm8));
        a_r9_inv_wide: assert (!inv_trap || (is_imm8 && cond_sel == COND_ALWAYS));
        a_r9_not_both: assert (!(is_nop && inv_trap));
        if (is_imm8)
            a_r2_wide_always: assert (cond_sel == COND_ALWAYS);
    end
endmodule

// File: tb/opnd_decoder_bench.sv
module opnd_decoder_bench;

    typedef struct packed {
        logic [15:0] word;
        logic [7:0]  rdata;
        logic [3:0]  opc;
        logic [7:0]  opnd;
        logic        wide;
        logic        shrt;
        logic [2:0]  idx;
        logic [2:0]  cond;
        logic        nop;
        logic        inv;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{16'h0000, 8'h3C, 4'h0, 8'h3C, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0},
        '{16'hFFFF, 8'h3C, 4'hF, 8'hFF, 1'b1, 1'b0, 3'd7, 3'd1, 1'b0, 1'b1},
        '{16'h0001, 8'h5A, 4'h0, 8'h5A, 1'b0, 1'b0, 3'd1, 3'd0, 1'b0, 1'b0},
        '{16'hFFFE, 8'h5A, 4'hF, 8'hFE, 1'b1, 1'b0, 3'd6, 3'd1, 1'b0, 1'b0},
        '{16'h6210, 8'hAA, 4'h6, 8'h01, 1'b0, 1'b1, 3'd0, 3'd1, 1'b0, 1'b0},
        '{16'h6217, 8'hAA, 4'h6, 8'h08, 1'b0, 1'b1, 3'd7, 3'd1, 1'b0, 1'b0},
        '{16'h6218, 8'hAA, 4'h6, 8'hF8, 1'b0, 1'b1, 3'd0, 3'd1, 1'b0, 1'b0},
        '{16'h621F, 8'hAA, 4'h6, 8'hFF, 1'b0, 1'b1, 3'd7, 3'd1, 1'b0, 1'b0},
        '{16'h3210, 8'hAA, 4'h3, 8'h00, 1'b0, 1'b1, 3'd0, 3'd1, 1'b0, 1'b0},
        '{16'h3257, 8'hAA, 4'h3, 8'h07, 1'b0, 1'b1, 3'd7, 3'd5, 1'b0, 1'b0},
        '{16'h321F, 8'hAA, 4'h3, 8'hFF, 1'b0, 1'b1, 3'd7, 3'd1, 1'b0, 1'b0},
        '{16'h3065, 8'hA5, 4'h3, 8'hA5, 1'b0, 1'b0, 3'd5, 3'd6, 1'b0, 1'b0},
        '{16'h34C3, 8'h11, 4'h3, 8'hC3, 1'b1, 1'b0, 3'd3, 3'd1, 1'b0, 1'b0},
        '{16'h6680, 8'h11, 4'h6, 8'h80, 1'b1, 1'b0, 3'd0, 3'd1, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic [15:0] instr_word = 16'h0000;
    logic [7:0]  rf_rdata = 8'h00;
    logic [3:0]  opcode;
    logic        is_imm8, is_short, is_nop, inv_trap;
    logic [7:0]  operand;
    logic [2:0]  reg_idx, cond_sel;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    opnd_decoder u_opnd_decoder (
        .instr_word (instr_word),
        .rf_rdata   (rf_rdata),
        .opcode     (opcode),
        .is_imm8    (is_imm8),
        .is_short   (is_short),
        .operand    (operand),
        .reg_idx    (reg_idx),
        .cond_sel   (cond_sel),
        .is_nop     (is_nop),
        .inv_trap   (inv_trap)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s word=%h actual=%h expected=%h",
                     req, what, instr_word, act, exp);
        end
    endtask

    task automatic apply(input logic [15:0] w, input logic [7:0] rd);
        @(posedge clk);
        instr_word = w;
        rf_rdata   = rd;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] e;
        // start-up state: all-zeros word with read data 0
        @(negedge clk);
        check("R8", "nop at start", 16'(is_nop), 16'd1);
        check("R4", "operand at start", 16'(operand), 16'h00);

        // vector table
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].word, VECS[i].rdata);
            check("R1", "opcode",   16'(opcode),   16'(VECS[i].opc));
            check("R2", "operand",  16'(operand),  16'(VECS[i].opnd));
            check("R2", "is_imm8",  16'(is_imm8),  16'(VECS[i].wide));
            check("R3", "is_short", 16'(is_short), 16'(VECS[i].shrt));
            check("R4", "reg_idx",  16'(reg_idx),  16'(VECS[i].idx));
            check("R7", "cond_sel", 16'(cond_sel), 16'(VECS[i].cond));
            check("R8", "is_nop",   16'(is_nop),   16'(VECS[i].nop));
            check("R9", "inv_trap", 16'(inv_trap), 16'(VECS[i].inv));
        end

        // R5: sweep all add short codes
        for (int c = 0; c < 16; c++) begin
            apply(16'h6210 | 16'(c), 8'h00);
            e = (c < 8) ? 8'(c + 1) : (8'(c) | 8'hF0);
            check("R5", "add short", 16'(operand), 16'(e));
            check("R5", "add nonzero", 16'(operand != 8'h00), 16'd1);
        end

        // R6: sweep short codes under a non-add opcode
        for (int c = 0; c < 16; c++) begin
            apply(16'hA200 | 16'(c), 8'h77);
            e = (c < 8) ? 8'(c) : (8'(c) | 8'hF0);
            check("R6", "sign ext", 16'(operand), 16'(e));
        end

        // R4: register form follows read data changes
        apply(16'h5012, 8'h00);
        check("R4", "rdata 00", 16'(operand), 16'h00);
        apply(16'h5012, 8'hFF);
        check("R4", "rdata FF", 16'(operand), 16'hFF);

        // R9: add opcode in wide form is not widened
        apply(16'h6400, 8'h99);
        check("R9", "wide no skip", 16'(operand), 16'h00);
        check("R9", "not trap", 16'(inv_trap), 16'd0);

        finish_run();
    end

endmodule